// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that software steps through a transfer one phase at a time. A four-entry register window gives access to a control word, a status word, a target address byte and one data byte that is shared between transmit and receive. Software starts the transfer, which sends the address, and then moves one data byte at a time. After each address or data byte the controller keeps SCL low. It waits there until software writes zero to the done flag of that phase. A STOP is asked for in advance by setting a force-stop control bit before the last phase is released.

Both bus lines are open-drain. The block pulls a line low when its output enable is high and reads the line back through a sampled input. The controller reports a missing acknowledge and a lost arbitration. A pin-override mode hands both lines straight to two control bits. Addressing is 7-bit only, and every phase moves exactly one byte.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads zero and both `scl_oe` and `sda_oe` are low. Register offsets: 0 control, 1 status, 2 target address, 3 data.
- R2: When control bit 3 (enable) and bit 0 (start) are set, a START is issued and the target address byte goes out MSB first. When the target acknowledges, status bit 0 (address done) and bit 3 (data empty) set and SCL stays held low.
- R3: Writing a status bit as 0 clears it. Writing it as 1 leaves it unchanged. Status bits never clear by any other means.
- R4: After a write address phase, clearing status bit 0 sends the data register. When that byte is acknowledged, status bit 3 and bit 2 (byte sent) set, and SCL is held low again. SDA changes only while SCL is driven low.
- R5: If control bit 1 (force stop) is set when the pending flag of a write phase is cleared, a STOP follows. Status bit 4 (stop done) then sets and both lines are released.
- R6: Address byte bit 0 = 1 selects a read. If force stop is set when status bit 0 is cleared, exactly one byte is received and NACKed. The byte is placed in the data register, status bit 1 (byte received) sets, and a STOP follows.
- R7: A high acknowledge on an address or write byte sets status bit 6. SCL then stays low until force stop is set, and a STOP follows.
- R8: If SDA reads low while the controller releases it during an address or write bit, status bit 5 sets. Both lines are released, and nothing more happens until enable is cleared.
- R9: While control bit 4 is set, `scl_oe` equals the inverse of control bit 6 and `sda_oe` equals the inverse of control bit 5. The sequencer does not advance in this mode, even with start requested.
- R10: While SCL is held after a byte, setting the start bit from 0 to 1 issues a repeated START. The address register is then sent with no STOP in between.
- R11: Writing zero to the control register after a STOP returns the controller to idle, and a later start runs a complete new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The repeated START is the hardest case to reach. It needs a write address phase, one data byte and a second start request while SCL is still held. The read address must reach the register before that request, and force stop must be set before the final release. The bench plays this exact register sequence against a clocked target model. That model counts STARTs and STOPs, returns a known byte, and records whether the master acknowledged it. Arbitration loss is produced by holding SDA low from the bench behind an address whose MSB is 1.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QDIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int DW = $clog2(QDIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_HOLD, S_STOP, S_PARK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_WR, K_RD} kind_t;
  typedef enum logic [1:0] {W_ADDR, W_DATA, W_RX, W_STOP} wait_t;

  logic [7:0] ctrl_q, addr_q, data_q, sh_q;
  logic [6:0] stat_q;
  st_t        state_q;
  kind_t      kind_q;
  wait_t      wait_q;
  logic [1:0] qtr_q;
  logic [3:0] bit_q;
  logic [DW-1:0] div_q;
  logic       esg_q, nak_q, last_q, rd_q;
  logic       fsm_scl, fsm_sda, go_on;

  wire ovr      = ctrl_q[4];
  wire mie      = ctrl_q[3];
  wire fsb      = ctrl_q[1];
  wire esg      = ctrl_q[0];
  wire wr_stat  = reg_we && reg_addr == 2'd1;
  wire tick     = div_q == DW'(QDIV - 1);
  wire esg_rise = esg && !esg_q;
  wire tx_bit   = kind_q != K_RD;

  always_comb begin
    fsm_scl = 1'b0;
    fsm_sda = 1'b0;
    case (state_q)
      S_START: begin fsm_scl = qtr_q == 2'd0 || qtr_q == 2'd3; fsm_sda = qtr_q[1]; end
      S_XFER: begin
        fsm_scl = !qtr_q[1];
        if (bit_q != 4'd8) fsm_sda = tx_bit && !sh_q[7];
        else               fsm_sda = !tx_bit && !last_q;
      end
      S_HOLD:  fsm_scl = 1'b1;
      S_STOP:  begin fsm_scl = !qtr_q[1]; fsm_sda = qtr_q == 2'd1 || qtr_q == 2'd2; end
      default: ;
    endcase
  end

  assign scl_oe = ovr ? !ctrl_q[6] : fsm_scl;
  assign sda_oe = ovr ? !ctrl_q[5] : fsm_sda;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = {1'b0, stat_q};
      2'd2:    reg_rdata = addr_q;
      default: reg_rdata = data_q;
    endcase
  end

  always_comb begin
    case (wait_q)
      W_ADDR:  go_on = !stat_q[0];
      W_DATA:  go_on = !stat_q[3];
      W_RX:    go_on = !stat_q[1];
      default: go_on = fsb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; addr_q <= '0; data_q <= '0; sh_q <= '0; stat_q <= '0;
      state_q <= S_IDLE; kind_q <= K_ADDR; wait_q <= W_ADDR;
      qtr_q <= '0; bit_q <= '0; div_q <= '0;
      esg_q <= 1'b0; nak_q <= 1'b0; last_q <= 1'b0; rd_q <= 1'b0;
    end else begin
      esg_q <= esg;
      if (reg_we) begin
        case (reg_addr)
          2'd0:    ctrl_q <= reg_wdata;
          2'd1:    stat_q <= stat_q & reg_wdata[6:0];
          2'd2:    addr_q <= reg_wdata;
          default: data_q <= reg_wdata;
        endcase
      end
      if (!ovr && (state_q == S_START || state_q == S_XFER || state_q == S_STOP))
        div_q <= tick ? '0 : div_q + DW'(1);
      else
        div_q <= '0;

      if (ovr) begin
        state_q <= state_q;
      end else if (!mie) begin
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (esg) begin state_q <= S_START; qtr_q <= '0; end
          S_HOLD: begin
            if (esg_rise) begin
              state_q <= S_START; qtr_q <= '0;
            end else if (go_on) begin
              qtr_q <= '0; bit_q <= '0;
              if (rd_q && wait_q != W_STOP) begin
                state_q <= S_XFER; kind_q <= K_RD; last_q <= fsb;
              end else if (fsb) begin
                state_q <= S_STOP;
              end else begin
                state_q <= S_XFER; kind_q <= K_WR; sh_q <= data_q;
              end
            end
          end
          S_START: if (tick) begin
            qtr_q <= qtr_q + 2'd1;
            if (qtr_q == 2'd3) begin
              state_q <= S_XFER; kind_q <= K_ADDR; sh_q <= addr_q; bit_q <= '0;
            end
          end
          S_STOP: if (tick) begin
            qtr_q <= qtr_q + 2'd1;
            if (qtr_q == 2'd3) begin state_q <= S_PARK; stat_q[4] <= 1'b1; end
          end
          S_XFER: if (tick) begin
            qtr_q <= qtr_q + 2'd1;
            if (qtr_q == 2'd2) begin
              if (bit_q == 4'd8)      nak_q <= sda_in;
              else if (!tx_bit)       sh_q <= {sh_q[6:0], sda_in};
              else if (sh_q[7] && !sda_in) begin state_q <= S_PARK; stat_q[5] <= 1'b1; end
            end
            if (qtr_q == 2'd3) begin
              if (bit_q != 4'd8) begin
                bit_q <= bit_q + 4'd1;
                if (tx_bit) sh_q <= {sh_q[6:0], 1'b0};
              end else if (kind_q == K_RD) begin
                data_q <= sh_q; stat_q[1] <= 1'b1;
                if (last_q) state_q <= S_STOP;
                else begin state_q <= S_HOLD; wait_q <= W_RX; end
              end else begin
                state_q <= S_HOLD;
                if (nak_q) begin
                  stat_q[6] <= 1'b1; wait_q <= W_STOP;
                end else if (kind_q == K_ADDR) begin
                  stat_q[0] <= 1'b1; stat_q[3] <= 1'b1; wait_q <= W_ADDR; rd_q <= addr_q[0];
                end else begin
                  stat_q[3] <= 1'b1; stat_q[2] <= 1'b1; wait_q <= W_DATA;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_stat_clear_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (($past(stat_q) & ~stat_q) == 7'd0));

  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XFER && !ovr && !$past(ovr) && !$stable(sda_oe)) |-> scl_oe);

  assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[4]) && !ovr) |-> (!scl_oe && !sda_oe));

  assert_arb_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[5]) && !ovr) |-> (!scl_oe && !sda_oe));

  assert_override_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && $past(ovr)) |-> $stable(state_q));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, scl_in, sda_in;
  logic tb_sda_low = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // target model state
  logic pscl = 1'b1, psda = 1'b1;
  logic s_act = 0, s_first = 0, s_rd = 0, s_drv = 0, s_nak = 0, s_mack = 0;
  logic [7:0] s_sh = '0, s_adr = '0, s_got = '0, s_tx = '0, s_txsh = '0;
  int s_cnt = 0, s_starts = 0, s_stops = 0;

  localparam logic [14:0] VEC [4] = '{{7'h50, 8'hA5}, {7'h23, 8'h00}, {7'h7F, 8'hFF}, {7'h01, 8'h3C}};

  always #10 clk = ~clk;

  assign scl_in = !scl_oe;
  assign sda_in = !sda_oe && !s_drv && !tb_sda_low;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    pscl <= scl_in;
    psda <= sda_in;
    if (pscl && scl_in && psda && !sda_in) begin
      s_act <= 1; s_cnt <= 0; s_first <= 1; s_rd <= 0; s_drv <= 0; s_starts <= s_starts + 1;
    end else if (pscl && scl_in && !psda && sda_in) begin
      s_act <= 0; s_drv <= 0; s_stops <= s_stops + 1;
    end else if (s_act && !pscl && scl_in) begin
      if (s_cnt < 8) s_sh <= {s_sh[6:0], sda_in};
      else s_mack <= sda_in;
      s_cnt <= s_cnt + 1;
    end else if (s_act && pscl && !scl_in) begin
      if (s_cnt == 8) begin
        if (s_first) begin s_adr <= s_sh; s_rd <= s_sh[0]; end
        else if (!s_rd) s_got <= s_sh;
        if (s_first || !s_rd) s_drv <= !s_nak;
        else s_drv <= 0;
      end else if (s_cnt == 9) begin
        s_cnt <= 0; s_first <= 0;
        if (s_rd && (s_first ? !s_nak : !s_mack)) begin
          s_drv <= !s_tx[7]; s_txsh <= {s_tx[6:0], 1'b0};
        end else s_drv <= 0;
      end else if (s_cnt >= 1 && s_rd && !s_first) begin
        s_drv <= !s_txsh[7]; s_txsh <= {s_txsh[6:0], 1'b0};
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_stat(input logic [6:0] m, input string req);
    logic [7:0] v;
    int n = 0;
    rdr(2'd1, v);
    while ((v[6:0] & m) != m && n < 20000) begin rdr(2'd1, v); n++; end
    if (n >= 20000) chk(0, req, v, m);
  endtask

  task automatic do_write(input logic [6:0] a7, input logic [7:0] d, input string req);
    s_nak = 0;
    wr(2, {a7, 1'b0}); wr(3, d); wr(1, 0); wr(0, 8'h89);
    wait_stat(7'h09, req);
    wr(0, 8'h88); wr(1, 8'hF6);
    wait_stat(7'h0C, req);
    wr(0, 8'h8A); wr(1, 8'hF7);
    wait_stat(7'h10, req);
  endtask

  initial begin
    logic [7:0] v;
    int st0, sp0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rdr(2'(i), v);
      chk(v == 8'h00, "R1 register zero", v, 0);
    end
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // R2 R3 R4 directed write with hold checks
    s_nak = 0;
    wr(2, 8'h6C); wr(3, 8'h5A); wr(0, 8'h89);
    wait_stat(7'h09, "R2");
    rdr(1, v); chk(v == 8'h09, "R2 address done flags", v, 8'h09);
    chk(s_adr == 8'h6C, "R2 address on bus", s_adr, 8'h6C);
    repeat (200) @(negedge clk);
    chk(scl_oe == 1'b1, "R2 SCL held low", scl_oe, 1);
    wr(1, 8'hFF);
    repeat (200) @(negedge clk);
    rdr(1, v); chk(v == 8'h09, "R3 write-one keeps flags", v, 8'h09);
    chk(scl_oe == 1'b1, "R3 no release on write-one", scl_oe, 1);
    wr(0, 8'h88); wr(1, 8'hF6);
    wait_stat(7'h0C, "R4");
    rdr(1, v); chk(v == 8'h0C, "R4 byte sent flags", v, 8'h0C);
    chk(s_got == 8'h5A, "R4 data on bus", s_got, 8'h5A);
    wr(0, 8'h8A); wr(1, 8'hF7);
    wait_stat(7'h10, "R5");
    wr(0, 0);

    // table-driven write transfers: R4 R5 R11
    for (int i = 0; i < 4; i++) begin
      sp0 = s_stops;
      do_write(VEC[i][14:8], VEC[i][7:0], "R11");
      rdr(1, v);
      chk(v == 8'h14, "R5 final status", v, 8'h14);
      chk(s_adr == {VEC[i][14:8], 1'b0}, "R2 table address", s_adr, {VEC[i][14:8], 1'b0});
      chk(s_got == VEC[i][7:0], "R4 table data", s_got, VEC[i][7:0]);
      chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
      chk(s_stops == sp0 + 1, "R11 one stop per transfer", s_stops - sp0, 1);
      wr(0, 0);
    end

    // R6 single read, last byte NACKed
    sp0 = s_stops; s_tx = 8'hC3; s_nak = 0;
    wr(2, 8'h45); wr(1, 0); wr(0, 8'h89);
    wait_stat(7'h09, "R6");
    wr(0, 8'h88); wr(0, 8'h8A); wr(1, 8'hFC);
    wait_stat(7'h12, "R6");
    rdr(3, v); chk(v == 8'hC3, "R6 received byte", v, 8'hC3);
    rdr(1, v); chk(v == 8'h1A, "R6 final status", v, 8'h1A);
    chk(s_mack == 1'b1, "R6 last byte NACKed", s_mack, 1);
    chk(s_stops == sp0 + 1, "R6 stop issued", s_stops - sp0, 1);
    wr(0, 0);

    // R10 repeated start: write register index then read
    st0 = s_starts; sp0 = s_stops; s_tx = 8'h96;
    wr(2, 8'h3A); wr(3, 8'h07); wr(1, 0); wr(0, 8'h89);
    wait_stat(7'h09, "R10");
    wr(0, 8'h88); wr(1, 8'hF6);
    wait_stat(7'h0C, "R10");
    wr(2, 8'h3B); wr(0, 8'h89);
    wait_stat(7'h01, "R10");
    chk(s_starts == st0 + 2 && s_stops == sp0, "R10 repeated start no stop", s_starts - st0, 2);
    wr(0, 8'h88); wr(0, 8'h8A); wr(1, 8'hFC);
    wait_stat(7'h12, "R10");
    rdr(3, v); chk(v == 8'h96, "R10 read after restart", v, 8'h96);
    chk(s_got == 8'h07 && s_adr == 8'h3B, "R10 index and read address", {s_got, s_adr}, 16'h073B);
    wait_stat(7'h10, "R10");
    rdr(1, v); chk(v == 8'h1E, "R10 final status", v, 8'h1E);
    wr(0, 0);

    // R7 address NACK
    sp0 = s_stops; s_nak = 1;
    wr(2, 8'h20); wr(1, 0); wr(0, 8'h89);
    wait_stat(7'h40, "R7");
    repeat (200) @(negedge clk);
    rdr(1, v); chk(v == 8'h40, "R7 nack flag only", v, 8'h40);
    chk(scl_oe == 1'b1 && s_stops == sp0, "R7 held until stop request", scl_oe, 1);
    wr(0, 8'h8A);
    wait_stat(7'h10, "R7");
    chk(s_stops == sp0 + 1, "R7 stop after request", s_stops - sp0, 1);
    wr(0, 0); s_nak = 0;

    // R8 arbitration loss
    tb_sda_low = 1;
    wr(2, 8'hA0); wr(1, 0); wr(0, 8'h89);
    wait_stat(7'h20, "R8");
    repeat (400) @(negedge clk);
    rdr(1, v); chk(v == 8'h20, "R8 arbitration flag", v, 8'h20);
    chk(!scl_oe && !sda_oe, "R8 lines released and parked", {scl_oe, sda_oe}, 0);
    tb_sda_low = 0;
    wr(0, 0); wr(1, 0);

    // R9 pin override
    wr(0, 8'h10); @(negedge clk);
    chk(scl_oe && sda_oe, "R9 force both low", {scl_oe, sda_oe}, 3);
    wr(0, 8'h50); @(negedge clk);
    chk(!scl_oe && sda_oe, "R9 SCL high SDA low", {scl_oe, sda_oe}, 1);
    st0 = s_starts;
    wr(0, 8'h79);
    repeat (300) @(negedge clk);
    rdr(1, v);
    chk(!scl_oe && !sda_oe && v == 8'h00 && s_starts == st0, "R9 start ignored in override", {scl_oe, sda_oe, v}, 0);
    wr(0, 0);

    summary();
  end
endmodule